// File: doc/BRIEF.md
# Active-Low Byte Handshake Link

This block carries one byte at a time between a host and a power-management microcontroller. The host picks a direction (send or receive), supplies a data byte when sending, and pulses a start strobe. The block configures its internal shift register for that direction, then pulls an active-low request line. The peer drives the shift clock as a one-cycle tick pulse, together with the serial data. The block counts the ticks. When it has counted a full byte it negates request, and it finishes once the active-low acknowledge line has returned high.

When it receives, the block clears its shift register at start and latches the assembled byte at the moment the shift completes. If acknowledge is already high at shift completion, the block raises a one-cycle protocol warning and carries on. If acknowledge does not come back high within a bounded number of clock cycles after request is released, the block gives up with a timeout strobe instead of a done strobe. The acknowledge input passes through a reset-to-high synchronizer. The byte width, the bit order, the timeout and the synchronizer depth are parameters.

Top module: `hs_byte_link`

## Requirements
- R1: After reset, req_n is 1, xfer_busy, xfer_done, xfer_timeout and proto_warn are 0, rx_byte is 0 and shift_out_en is 0 (shift-in).
- R2: A xfer_start pulse while idle makes xfer_busy 1 and req_n 0 at the next clock edge, and shift_out_en takes the value of xfer_send (1 = shift out, 0 = shift in).
- R3: When sending, ser_out shows tx_byte most significant bit first: bit 7 right after start, then the next lower bit after each shift_tick.
- R4: When receiving, the register is cleared at start and ser_in is sampled on each shift_tick, first sample into bit 7. rx_byte takes the assembled byte on the edge of the eighth tick. A send leaves rx_byte unchanged.
- R5: On the edge of the eighth shift_tick, req_n returns to 1. shift_tick pulses while idle, or after the eighth tick, change neither rx_byte nor the transfer.
- R6: xfer_done is a one-cycle pulse that comes only after the synchronized ack_n has been seen high following release of request. The block is idle in the same cycle.
- R7: If ack_n stays low, xfer_timeout pulses exactly TIMEOUT_CYC cycles after the edge that released request, and no xfer_done is produced.
- R8: If the synchronized ack_n is already high on the edge that completes the shift, proto_warn pulses for one cycle and the transfer still ends with xfer_done.
- R9: xfer_start pulses during a busy transfer are ignored: direction, transmitted bits and result are those of the transfer already running.
- R10: xfer_done and xfer_timeout are never both 1, and xfer_busy is 0 in the cycle either of them is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_start | input | 1 | Start strobe for one byte transfer |
| xfer_send | input | 1 | Direction: 1 send, 0 receive |
| tx_byte | input | DATA_W | Byte to send |
| rx_byte | output | DATA_W | Last received byte |
| xfer_busy | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle completion pulse |
| xfer_timeout | output | 1 | One-cycle acknowledge timeout pulse |
| proto_warn | output | 1 | One-cycle pulse: acknowledge was high at shift completion |
| req_n | output | 1 | Request to peer, active low |
| ack_n | input | 1 | Acknowledge from peer, active low |
| shift_out_en | output | 1 | Shift direction setting: 1 shift out, 0 shift in |
| shift_tick | input | 1 | One-cycle pulse per peer shift clock, already synchronous to clk |
| ser_in | input | 1 | Serial data from peer, sampled on shift_tick |
| ser_out | output | 1 | Serial data to peer |

## Verification
The properties assume that shift_tick is a single-cycle pulse synchronous to clk, and that ack_n changes slowly compared with the synchronizer depth. The window check assumes the peer releases acknowledge well inside TIMEOUT_CYC, except in the one timeout scenario. The stimulus drives every input at the falling edge, and the peer model holds ack_n low from shortly after request falls. It releases ack_n after a random delay of at most six cycles, which is well below the bench timeout of twenty cycles. Only the dedicated directed cases hold acknowledge low for good or keep it high through the whole byte.

// File: rtl/hs_link_pkg.sv
package hs_link_pkg;
   typedef enum logic [1:0] {
      LNK_IDLE  = 2'd0,
      LNK_SHIFT = 2'd1,
      LNK_WAIT  = 2'd2
   } lnk_state_t;
endpackage

// File: rtl/hs_ack_sync.sv
module hs_ack_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= STAGES'({chain, din});
         end
         assign dout = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/hs_shifter.sv
module hs_shifter #(
   parameter int DATA_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              clear,
   input  logic              tick,
   input  logic              ser_in,
   input  logic [DATA_W-1:0] load_val,
   output logic              ser_out,
   output logic              last,
   output logic [DATA_W-1:0] nxt
);
   localparam int CW = (DATA_W > 2) ? $clog2(DATA_W) : 1;

   logic [DATA_W-1:0] q;
   logic [CW-1:0]     cnt;

   generate
      if (MSB_FIRST) begin : g_msb
         assign nxt     = {q[DATA_W-2:0], ser_in};
         assign ser_out = q[DATA_W-1];
      end else begin : g_lsb
         assign nxt     = {ser_in, q[DATA_W-1:1]};
         assign ser_out = q[0];
      end
   endgenerate

   assign last = tick && (cnt == CW'(DATA_W-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q   <= '0;
         cnt <= '0;
      end else if (load) begin
         q   <= load_val;
         cnt <= '0;
      end else if (clear) begin
         q   <= '0;
         cnt <= '0;
      end else if (tick) begin
         q   <= nxt;
         cnt <= last ? '0 : cnt + 1'b1;
      end
   end
endmodule

// File: rtl/hs_ack_timer.sv
module hs_ack_timer #(
   parameter int LIMIT = 3200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic expired
);
   localparam int CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt;

   assign expired = run && (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clear) cnt <= '0;
      else if (run)   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/hs_byte_link.sv
module hs_byte_link
   import hs_link_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int TIMEOUT_CYC = 3200,
   parameter int SYNC_STAGES = 2,
   parameter bit MSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_start,
   input  logic              xfer_send,
   input  logic [DATA_W-1:0] tx_byte,
   output logic [DATA_W-1:0] rx_byte,
   output logic              xfer_busy,
   output logic              xfer_done,
   output logic              xfer_timeout,
   output logic              proto_warn,
   output logic              req_n,
   input  logic              ack_n,
   output logic              shift_out_en,
   input  logic              shift_tick,
   input  logic              ser_in,
   output logic              ser_out
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("hs_byte_link: DATA_W must be at least 2");
      end
      if (TIMEOUT_CYC < 2) begin : g_bad_timeout
         $error("hs_byte_link: TIMEOUT_CYC must be at least 2");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("hs_byte_link: SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   lnk_state_t        state;
   logic              ack_hi;
   logic              dir_q;
   logic              go;
   logic              sh_tick;
   logic              sh_last;
   logic [DATA_W-1:0] sh_nxt;
   logic              tmr_expired;

   assign go      = (state == LNK_IDLE) && xfer_start;
   assign sh_tick = (state == LNK_SHIFT) && shift_tick;

   hs_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (ack_n),
      .dout  (ack_hi)
   );

   hs_shifter #(.DATA_W(DATA_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (go && xfer_send),
      .clear    (go && !xfer_send),
      .tick     (sh_tick),
      .ser_in   (ser_in),
      .load_val (tx_byte),
      .ser_out  (ser_out),
      .last     (sh_last),
      .nxt      (sh_nxt)
   );

   hs_ack_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (state != LNK_WAIT),
      .run     ((state == LNK_WAIT) && !ack_hi),
      .expired (tmr_expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= LNK_IDLE;
         req_n        <= 1'b1;
         dir_q        <= 1'b0;
         rx_byte      <= '0;
         xfer_done    <= 1'b0;
         xfer_timeout <= 1'b0;
         proto_warn   <= 1'b0;
      end else begin
         xfer_done    <= 1'b0;
         xfer_timeout <= 1'b0;
         proto_warn   <= 1'b0;
         unique case (state)
            LNK_IDLE: begin
               if (xfer_start) begin
                  dir_q <= xfer_send;
                  req_n <= 1'b0;
                  state <= LNK_SHIFT;
               end
            end
            LNK_SHIFT: begin
               if (sh_last) begin
                  if (!dir_q) rx_byte <= sh_nxt;
                  proto_warn <= ack_hi;
                  req_n      <= 1'b1;
                  state      <= LNK_WAIT;
               end
            end
            LNK_WAIT: begin
               if (ack_hi) begin
                  xfer_done <= 1'b1;
                  state     <= LNK_IDLE;
               end else if (tmr_expired) begin
                  xfer_timeout <= 1'b1;
                  state        <= LNK_IDLE;
               end
            end
            default: state <= LNK_IDLE;
         endcase
      end
   end

   assign xfer_busy    = (state != LNK_IDLE);
   assign shift_out_en = dir_q;
endmodule

// File: rtl/hs_byte_link_chk.sv
module hs_byte_link_chk #(
   parameter int TIMEOUT_CYC = 3200
) (
   input logic clk,
   input logic rst_n,
   input logic xfer_start,
   input logic xfer_busy,
   input logic xfer_done,
   input logic xfer_timeout,
   input logic proto_warn,
   input logic req_n,
   input logic shift_out_en
);
   localparam int WW = $clog2(TIMEOUT_CYC + 2) + 1;

   logic [WW-1:0] rel_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 rel_cnt <= '0;
      else if (xfer_busy && req_n) rel_cnt <= rel_cnt + 1'b1;
      else                        rel_cnt <= '0;
   end

   assert_idle_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_busy |-> req_n);

   assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_start && !xfer_busy) |=> (xfer_busy && !req_n));

   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> (!xfer_done && !xfer_busy));

   assert_done_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> req_n);

   assert_wait_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rel_cnt <= WW'(TIMEOUT_CYC));

   assert_timeout_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_timeout |-> (!xfer_busy && req_n));

   assert_warn_R8: assert property (@(posedge clk) disable iff (!rst_n)
      proto_warn |-> (xfer_busy && req_n));

   assert_dir_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_busy && $past(xfer_busy)) |-> $stable(shift_out_en));

   assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({xfer_done, xfer_timeout}));
endmodule

bind hs_byte_link hs_byte_link_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .xfer_start   (xfer_start),
   .xfer_busy    (xfer_busy),
   .xfer_done    (xfer_done),
   .xfer_timeout (xfer_timeout),
   .proto_warn   (proto_warn),
   .req_n        (req_n),
   .shift_out_en (shift_out_en)
);

// File: tb/hs_byte_link_test.sv
module hs_byte_link_test;
   localparam int CLK_PERIOD = 10;
   localparam int TMO        = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       xfer_start = 1'b0;
   logic       xfer_send = 1'b0;
   logic [7:0] tx_byte = '0;
   logic [7:0] rx_byte;
   logic       xfer_busy, xfer_done, xfer_timeout, proto_warn;
   logic       req_n;
   logic       ack_n = 1'b1;
   logic       shift_out_en;
   logic       shift_tick = 1'b0;
   logic       ser_in = 1'b0;
   logic       ser_out;

   int n_chk = 0;
   int n_fail = 0;
   int dones = 0;
   int tmos = 0;
   logic [7:0] exp_rx = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hs_byte_link #(.DATA_W(8), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2), .MSB_FIRST(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_send(xfer_send),
      .tx_byte(tx_byte), .rx_byte(rx_byte), .xfer_busy(xfer_busy),
      .xfer_done(xfer_done), .xfer_timeout(xfer_timeout), .proto_warn(proto_warn),
      .req_n(req_n), .ack_n(ack_n), .shift_out_en(shift_out_en),
      .shift_tick(shift_tick), .ser_in(ser_in), .ser_out(ser_out)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic step();
      @(negedge clk);
      dones += int'(xfer_done);
      tmos  += int'(xfer_timeout);
   endtask

   // one byte transfer with a cooperating peer
   task automatic run_xfer(input bit send, input logic [7:0] data, input logic [7:0] bits,
                           input int ack_dly, input bit warn_mode, input bit poke, input bit late_tick);
      @(negedge clk);
      xfer_start = 1'b1; xfer_send = send; tx_byte = data;
      @(negedge clk);
      xfer_start = 1'b0;
      chk("R2 busy", xfer_busy, 1);
      chk("R2 req_n", req_n, 0);
      chk("R2 dir", shift_out_en, send);
      if (!warn_mode) ack_n = 1'b0;
      if (poke) begin
         xfer_start = 1'b1; xfer_send = !send; tx_byte = ~data;
         @(negedge clk);
         xfer_start = 1'b0;
         chk("R9 busy", xfer_busy, 1);
         chk("R9 dir", shift_out_en, send);
      end
      for (int i = 0; i < 8; i++) begin
         if (send) chk("R3 ser_out", ser_out, data[7-i]);
         shift_tick = 1'b1; ser_in = bits[7-i];
         @(negedge clk);
         shift_tick = 1'b0;
         if (i < 7) chk("R5 req held", req_n, 0);
      end
      if (!send) exp_rx = bits;
      dones = 0; tmos = 0;
      chk("R5 req release", req_n, 1);
      chk("R8 warn", proto_warn, warn_mode);
      chk("R4 rx_byte", rx_byte, exp_rx);
      if (late_tick && !warn_mode) begin
         shift_tick = 1'b1; ser_in = ~bits[0];
         step();
         shift_tick = 1'b0;
         chk("R5 late tick busy", xfer_busy, 1);
         chk("R5 late tick rx", rx_byte, exp_rx);
      end
      for (int d = 0; d < ack_dly; d++) step();
      ack_n = 1'b1;
      for (int d = 0; d < 6; d++) step();
      chk("R6 done count", dones, 1);
      chk("R10 no timeout", tmos, 0);
      chk("R10 idle", xfer_busy, 0);
      chk("R4 rx final", rx_byte, exp_rx);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      int n;
      void'($urandom(32'h5eed_0042));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 req_n", req_n, 1);
      chk("R1 busy", xfer_busy, 0);
      chk("R1 done", xfer_done, 0);
      chk("R1 timeout", xfer_timeout, 0);
      chk("R1 warn", proto_warn, 0);
      chk("R1 rx", rx_byte, 0);
      chk("R1 dir", shift_out_en, 0);

      // directed corners
      run_xfer(1'b1, 8'hA5, 8'h00, 0, 1'b0, 1'b0, 1'b0);
      run_xfer(1'b0, 8'h00, 8'h5A, 2, 1'b0, 1'b0, 1'b0);
      run_xfer(1'b0, 8'h00, 8'hFF, 1, 1'b0, 1'b0, 1'b1);
      run_xfer(1'b1, 8'h00, 8'h3C, 3, 1'b0, 1'b0, 1'b1);
      run_xfer(1'b1, 8'hFF, 8'h00, 0, 1'b0, 1'b1, 1'b0);
      run_xfer(1'b0, 8'h81, 8'h81, 4, 1'b0, 1'b1, 1'b0);
      run_xfer(1'b0, 8'h00, 8'hC3, 0, 1'b1, 1'b0, 1'b0);
      run_xfer(1'b1, 8'h96, 8'h00, 0, 1'b1, 1'b0, 1'b0);

      // idle ticks are ignored (R5)
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         shift_tick = 1'b1; ser_in = 1'b1;
         @(negedge clk);
         shift_tick = 1'b0;
         chk("R5 idle tick busy", xfer_busy, 0);
         chk("R5 idle tick req", req_n, 1);
         chk("R5 idle tick rx", rx_byte, exp_rx);
      end

      // acknowledge stuck low -> timeout (R7)
      @(negedge clk);
      xfer_start = 1'b1; xfer_send = 1'b0;
      @(negedge clk);
      xfer_start = 1'b0;
      ack_n = 1'b0;
      for (int i = 0; i < 8; i++) begin
         shift_tick = 1'b1; ser_in = i[0];
         @(negedge clk);
         shift_tick = 1'b0;
      end
      exp_rx = 8'h55;
      chk("R7 req released", req_n, 1);
      n = 0; dones = 0;
      do begin
         @(negedge clk);
         n++;
         dones += int'(xfer_done);
      end while (!xfer_timeout && n < 100);
      chk("R7 timeout cycle", n, TMO);
      chk("R7 no done", dones, 0);
      chk("R10 idle at timeout", xfer_busy, 0);
      chk("R4 rx on timeout path", rx_byte, exp_rx);
      ack_n = 1'b1;
      repeat (4) @(negedge clk);

      // constrained random transfers
      for (int k = 0; k < 40; k++) begin
         run_xfer(1'($urandom_range(1, 0)), 8'($urandom_range(255, 0)),
                  8'($urandom_range(255, 0)), int'($urandom_range(6, 0)),
                  1'($urandom_range(7, 0) == 0), 1'($urandom_range(3, 0) == 0),
                  1'($urandom_range(3, 0) == 0));
      end

      summary();
      $finish;
   end
endmodule